// File: doc/BRIEF.md
# Correlating Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps one global shift register holding the directions of the most recent resolved branches. It also keeps a table of small saturating counters. To pick a counter, the block joins a few low bits of the branch address (the row) with the current global history (the column). Each address row therefore has one counter for every possible recent-outcome pattern. The prediction is taken when the selected counter sits in its upper half.

The lookup side is purely combinational from the stored state. The fetch logic presents a PC on `lkp_pc` and reads `lkp_taken` in the same cycle. When a branch resolves, the back end presents its PC and real direction on the update side for one cycle. At the next clock edge the block moves only the counter selected by that PC and the current history, and then shifts the outcome into the history. There are no tags. Branches whose row bits match share a row and interfere with each other.

Top module: `gbp_predictor`

## Requirements
- R1: After a synchronous active-high reset, every counter holds 1 (weakly not taken) and the history holds 0, so a lookup of any row predicts not taken (`lkp_taken` = 0).
- R2: The row is PC bits [5:2]. The counter index is {row, history}. PC bits outside [5:2] do not influence the selection, so two PCs that differ only above bit 5 alias to the same counters. An update to one row does not change the prediction of another row.
- R3: `lkp_taken` is 1 exactly when the selected 2-bit counter is 2 or 3.
- R4: An update with `upd_taken` = 1 raises only the selected counter by one, and the counter saturates at 3.
- R5: An update with `upd_taken` = 0 lowers only the selected counter by one, and the counter saturates at 0.
- R6: After each update the 2-bit history shifts left and the new outcome enters at bit 0 (taken = 1). The history value 01 therefore means not taken, then taken. The following lookups select counters with the new history.
- R7: A counter that has saturated at strongly taken keeps predicting taken after one not-taken outcome. It predicts not taken only after a second one.
- R8: A lookup in the same cycle as an update sees the table and history as they were before that update.
- R9: While `upd_valid` is 0, `upd_pc` and `upd_taken` change neither the counters nor the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lkp_pc | input | 32 | PC of the branch being predicted |
| lkp_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
A vector table runs one row through every history pattern. It shows that the four counters of a row are separate and that history, not only the address, picks the counter. It also checks a second row and a PC that differs only above bit 5, which tell row separation apart from aliasing. Same-cycle lookups against updates show whether the read sees the old or the new state. Directed runs drive one counter against its top and bottom limits and then step it back. A wrapping counter gives a different answer from a saturating one there. The same runs count the mispredictions needed to flip a strong counter, and they show whether inputs held while `upd_valid` is low leak into the state.

// File: rtl/bp_pkg.sv
package bp_pkg;

    localparam int MAX_CTR_W = 8;

    typedef logic [MAX_CTR_W-1:0] wide_ctr_t;

    typedef enum logic {
        DIR_NOT_TAKEN = 1'b0,
        DIR_TAKEN     = 1'b1
    } dir_e;

    // Saturating step of a counter whose ceiling is 'top'.
    function automatic wide_ctr_t sat_step(wide_ctr_t cur, wide_ctr_t top, dir_e dir);
        if (dir == DIR_TAKEN) begin
            return (cur == top) ? cur : cur + 1'b1;
        end
        return (cur == '0) ? cur : cur - 1'b1;
    endfunction

    // Largest value of a w-bit counter.
    function automatic wide_ctr_t ctr_ceiling(int unsigned w);
        return wide_ctr_t'((1 << w) - 1);
    endfunction

    // Value just below the taken threshold of a w-bit counter.
    function automatic wide_ctr_t weak_not_taken(int unsigned w);
        return wide_ctr_t'((1 << (w - 1)) - 1);
    endfunction

    // Upper half of the counter range means predict taken.
    function automatic logic upper_half(wide_ctr_t cur, int unsigned w);
        return cur >= wide_ctr_t'(1 << (w - 1));
    endfunction

endpackage

// File: rtl/bp_ghist.sv
module bp_ghist
    import bp_pkg::*;
#(
    parameter int HIST_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 shift_en,
    input  dir_e                 outcome,
    output logic [HIST_BITS-1:0] hist
);

    logic [HIST_BITS-1:0] hist_q;

    generate
        if (HIST_BITS == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    hist_q <= '0;
                end else if (shift_en) begin
                    hist_q <= outcome;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) begin
                    hist_q <= '0;
                end else if (shift_en) begin
                    hist_q <= {hist_q[HIST_BITS-2:0], outcome};
                end
            end
        end
    endgenerate

    assign hist = hist_q;

endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
    import bp_pkg::*;
#(
    parameter int IDX_BITS = 6,
    parameter int CTR_BITS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [IDX_BITS-1:0] rd_idx,
    output logic [CTR_BITS-1:0] rd_ctr,
    input  logic                wr_en,
    input  logic [IDX_BITS-1:0] wr_idx,
    input  dir_e                wr_dir
);

    localparam int ENTRIES = 1 << IDX_BITS;
    localparam wide_ctr_t TOP_W  = ctr_ceiling(CTR_BITS);
    localparam wide_ctr_t INIT_W = weak_not_taken(CTR_BITS);
    localparam logic [CTR_BITS-1:0] INIT = INIT_W[CTR_BITS-1:0];

    logic [CTR_BITS-1:0] cells [ENTRIES];
    logic [CTR_BITS-1:0] wr_cur;
    logic [CTR_BITS-1:0] wr_next;
    wide_ctr_t           wr_next_w;

    // One shared step circuit feeds whichever entry is written.
    always_comb begin
        wr_cur    = cells[wr_idx];
        wr_next_w = sat_step(wide_ctr_t'(wr_cur), TOP_W, wr_dir);
        wr_next   = wr_next_w[CTR_BITS-1:0];
    end

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_cell
            logic [CTR_BITS-1:0] cell_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    cell_q <= INIT;
                end else if (wr_en && (wr_idx == IDX_BITS'(e))) begin
                    cell_q <= wr_next;
                end
            end
            assign cells[e] = cell_q;
        end
    endgenerate

    assign rd_ctr = cells[rd_idx];

endmodule

// File: rtl/gbp_predictor.sv
module gbp_predictor
    import bp_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int PC_LSB    = 2,
    parameter int ROW_BITS  = 4,
    parameter int HIST_BITS = 2,
    parameter int CTR_BITS  = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lkp_pc,
    output logic            lkp_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);

    localparam int IDX_BITS = ROW_BITS + HIST_BITS;
    localparam int ROW_MSB  = PC_LSB + ROW_BITS - 1;

    logic [HIST_BITS-1:0] ghist;
    logic [ROW_BITS-1:0]  lkp_row;
    logic [ROW_BITS-1:0]  upd_row;
    logic [IDX_BITS-1:0]  lkp_idx;
    logic [IDX_BITS-1:0]  upd_idx;
    logic [CTR_BITS-1:0]  lkp_ctr;
    dir_e                 upd_dir;
    logic                 unused_pc_bits;

    assign lkp_row = lkp_pc[ROW_MSB:PC_LSB];
    assign upd_row = upd_pc[ROW_MSB:PC_LSB];
    assign lkp_idx = {lkp_row, ghist};
    assign upd_idx = {upd_row, ghist};
    assign upd_dir = upd_taken ? DIR_TAKEN : DIR_NOT_TAKEN;
    assign unused_pc_bits = ^{lkp_pc, upd_pc};

    bp_ctr_table #(
        .IDX_BITS (IDX_BITS),
        .CTR_BITS (CTR_BITS)
    ) u_table (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (lkp_idx),
        .rd_ctr (lkp_ctr),
        .wr_en  (upd_valid),
        .wr_idx (upd_idx),
        .wr_dir (upd_dir)
    );

    bp_ghist #(
        .HIST_BITS (HIST_BITS)
    ) u_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (upd_valid),
        .outcome  (upd_dir),
        .hist     (ghist)
    );

    assign lkp_taken = upper_half(wide_ctr_t'(lkp_ctr), CTR_BITS);

endmodule

// File: rtl/gbp_predictor_chk.sv
module gbp_predictor_chk #(
    parameter int PC_W      = 32,
    parameter int HIST_BITS = 2,
    parameter int CTR_BITS  = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic [PC_W-1:0]      lkp_pc,
    input logic                 lkp_taken,
    input logic                 upd_valid,
    input logic                 upd_taken,
    input logic [HIST_BITS-1:0] hist,
    input logic [CTR_BITS-1:0]  lkp_ctr
);

    localparam logic [CTR_BITS-1:0] HALF = {1'b1, {(CTR_BITS-1){1'b0}}};

    // R1: history is clear on the first cycle out of reset
    assert_hist_cleared_R1: assert property (@(posedge clk)
        $past(rst) |-> (hist == '0));

    // R3: direction follows the range of the selected counter
    assert_upper_half_R3: assert property (@(posedge clk) disable iff (rst)
        lkp_taken == (lkp_ctr >= HALF));

    // R6: newest outcome lands in the lowest history bit
    assert_hist_entry_R6: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> (hist[0] == $past(upd_taken)));

    generate
        if (HIST_BITS > 1) begin : g_age
            // R6: older outcomes move up one place
            assert_hist_age_R6: assert property (@(posedge clk) disable iff (rst)
                upd_valid |=> (hist[HIST_BITS-1:1] == $past(hist[HIST_BITS-2:0])));
        end
    endgenerate

    // R9: no update, no history movement
    assert_hist_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(hist));

    // R9: no update and the same lookup PC gives the same answer
    assert_pred_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> ((lkp_pc != $past(lkp_pc)) || (lkp_taken == $past(lkp_taken))));

endmodule

bind gbp_predictor gbp_predictor_chk #(
    .PC_W      (PC_W),
    .HIST_BITS (HIST_BITS),
    .CTR_BITS  (CTR_BITS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lkp_pc    (lkp_pc),
    .lkp_taken (lkp_taken),
    .upd_valid (upd_valid),
    .upd_taken (upd_taken),
    .hist      (ghist),
    .lkp_ctr   (lkp_ctr)
);

// File: tb/gbp_predictor_tb.sv
module gbp_predictor_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] lkp_pc = '0;
    logic        lkp_taken;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    gbp_predictor u_dut (
        .clk       (clk),
        .rst       (rst),
        .lkp_pc    (lkp_pc),
        .lkp_taken (lkp_taken),
        .upd_valid (upd_valid),
        .upd_pc    (upd_pc),
        .upd_taken (upd_taken)
    );

    // {upd_valid, upd_pc[7:0], upd_taken, lkp_pc[7:0], expected prediction}
    localparam int NVEC = 14;
    localparam logic [18:0] VEC [NVEC] = '{
        {1'b0, 8'h0C, 1'b0, 8'h0C, 1'b0},
        {1'b1, 8'h0C, 1'b1, 8'h0C, 1'b0},
        {1'b0, 8'h0C, 1'b1, 8'h0C, 1'b0},
        {1'b1, 8'h0C, 1'b1, 8'h0C, 1'b0},
        {1'b1, 8'h0C, 1'b0, 8'h0C, 1'b0},
        {1'b1, 8'h0C, 1'b1, 8'h0C, 1'b0},
        {1'b0, 8'h00, 1'b0, 8'h0C, 1'b1},
        {1'b0, 8'h00, 1'b0, 8'h14, 1'b0},
        {1'b1, 8'h14, 1'b1, 8'h0C, 1'b1},
        {1'b0, 8'h00, 1'b0, 8'h0C, 1'b0},
        {1'b1, 8'h0C, 1'b1, 8'h0C, 1'b0},
        {1'b1, 8'h0C, 1'b1, 8'h0C, 1'b0},
        {1'b0, 8'h0C, 1'b0, 8'h0C, 1'b1},
        {1'b0, 8'h00, 1'b0, 8'h4C, 1'b1}
    };

    task automatic check(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: lkp_taken=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        upd_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic look(input logic [7:0] pc, input logic exp, input string req);
        lkp_pc = {24'h0, pc};
        #1;
        check(lkp_taken, exp, req);
    endtask

    task automatic do_upd(input logic [7:0] pc, input logic t);
        upd_valid = 1'b1;
        upd_pc    = {24'h0, pc};
        upd_taken = t;
        @(posedge clk);
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        do_reset();

        // Table walk: R2 rows and aliasing, R3 threshold, R6 history select, R8 pre-update read
        for (int i = 0; i < NVEC; i++) begin
            upd_valid = VEC[i][18];
            upd_pc    = {24'h0, VEC[i][17:10]};
            upd_taken = VEC[i][9];
            lkp_pc    = {24'h0, VEC[i][8:1]};
            #1;
            check(lkp_taken, VEC[i][0], $sformatf("R2/R3/R6/R8 vector %0d", i));
            @(posedge clk);
            @(negedge clk);
        end
        upd_valid = 1'b0;

        // R1: every row predicts not taken after reset
        do_reset();
        for (int r = 0; r < 16; r++) begin
            look(8'(r << 2), 1'b0, $sformatf("R1 row %0d", r));
        end

        // R9: update fields without valid leave state untouched
        do_reset();
        upd_valid = 1'b0;
        upd_pc    = 32'h08;
        upd_taken = 1'b1;
        repeat (3) @(negedge clk);
        look(8'h08, 1'b0, "R9 ignored update");

        // R4 ceiling and R7 hysteresis on row 9
        do_reset();
        for (int j = 0; j < 7; j++) do_upd(8'h24, 1'b1);
        look(8'h24, 1'b1, "R4 strongly taken");
        do_upd(8'h24, 1'b0);
        do_upd(8'h28, 1'b1);
        do_upd(8'h28, 1'b1);
        look(8'h24, 1'b1, "R4/R7 one miss keeps taken");
        do_upd(8'h24, 1'b0);
        do_upd(8'h28, 1'b1);
        do_upd(8'h28, 1'b1);
        look(8'h24, 1'b0, "R7 second miss flips");

        // R5 floor on row 7
        do_reset();
        for (int j = 0; j < 3; j++) do_upd(8'h1C, 1'b0);
        do_upd(8'h1C, 1'b1);
        do_upd(8'h20, 1'b0);
        do_upd(8'h20, 1'b0);
        look(8'h1C, 1'b0, "R5 floor then one step up");
        do_upd(8'h1C, 1'b1);
        do_upd(8'h20, 1'b0);
        do_upd(8'h20, 1'b0);
        look(8'h1C, 1'b1, "R5 second step up crosses threshold");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule